// File: doc/BRIEF.md
# Shift, Rotate and Byte-Reorder Unit

This combinational datapath block sits beside the adder in a small processor core. It handles every data-movement operation that rearranges bits rather than adding them. It covers logical shifts in both directions, the arithmetic right shift and the right rotate. It also reorders bytes within a word or within its halfwords, and it widens a byte or halfword to a full word with sign or zero fill. One 4-bit opcode selects the operation. The result appears on the same cycle, together with negative, zero and carry flags that the core's flag register may capture.

Shift amounts come from one of two places. The first is a short immediate taken from the instruction. The second is the low byte of a register operand, which the core delivers as an 8-bit amount. The carry input is the core's current carry flag. It passes through whenever an operation does not define a new carry.

Top module: `bitmove_unit`

## Requirements
- R1: Opcodes are 0 left shift, 1 logical right shift, 2 arithmetic right shift, 3 right rotate, 4 reverse all bytes, 5 swap bytes within each halfword, 6 signed halfword byte swap, 7 sign-extend byte, 8 sign-extend halfword, 9 zero-extend byte, 10 zero-extend halfword. Codes 11 to 15 return the data input unchanged, with carry_o equal to carry_i.
- R2: A left shift by n, with 1 <= n <= 31, gives a_i << n and carry a_i[32-n]. A shift by 32 gives 0 with carry a_i[0]. A shift above 32 gives 0 with carry 0.
- R3: A logical right shift by n, with 1 <= n <= 31, gives a_i >> n and carry a_i[n-1]. A shift by 32 gives 0 with carry a_i[31]. A shift above 32 gives 0 with carry 0.
- R4: An arithmetic right shift by n, with 1 <= n <= 31, fills with a_i[31] and gives carry a_i[n-1]. Any amount of 32 or more makes every result bit, and the carry, equal to a_i[31].
- R5: For opcodes 0 to 2, amt_sel_i = 0 takes the amount from imm_amt_i, and amt_sel_i = 1 takes it from reg_amt_i. The unused source has no effect.
- R6: For any shift or rotate whose selected amount is zero, res_o equals a_i and carry_o equals carry_i.
- R7: A rotate always takes its amount from reg_amt_i, whatever amt_sel_i and imm_amt_i are. It rotates right by that amount modulo 32. For a nonzero amount, carry_o equals res_o[31].
- R8: Opcode 4 gives {a_i[7:0], a_i[15:8], a_i[23:16], a_i[31:24]}.
- R9: Opcode 5 gives {a_i[23:16], a_i[31:24], a_i[7:0], a_i[15:8]}.
- R10: Opcode 6 gives {a_i[7:0], a_i[15:8]}, sign-extended from bit 7 of a_i to 32 bits.
- R11: Opcodes 7 to 10 extend a_i[7:0] or a_i[15:0] to 32 bits. Opcodes 7 and 8 copy the top bit of the field upward, and opcodes 9 and 10 fill with zeros.
- R12: For every opcode, neg_o equals res_o[31] and zero_o is 1 exactly when res_o is all zeros. For opcodes 4 to 15, carry_o equals carry_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (see R1) |
| amt_sel_i | input | 1 | 0 = shift amount from immediate, 1 = from register byte |
| imm_amt_i | input | 5 | Immediate shift amount |
| reg_amt_i | input | 8 | Low byte of the register holding the shift amount |
| a_i | input | 32 | Data operand |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 32 | Result word |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag after the operation |

## Verification
The block holds no state, so any fault in a shift stage, a byte lane or a flag term shows on res_o or the flags in the same cycle as the stimulus that reaches it. The faults most likely to hide sit where the amounts meet their edges: 0, 31, 32, just above 32 and 255. Others sit where rotate amounts wrap modulo 32, or where the unused amount source is fed by mistake. The stimulus therefore pins each of those edges before sweeping random operands and amounts across all sixteen opcodes.

// File: rtl/bitmove_pkg.sv
// Package: shared operation codes for the shift / byte-reorder unit.
// Assumes: a 4-bit opcode; the low two bits of opcodes 0..3 name the shift kind.
package bitmove_pkg;

    typedef enum logic [3:0] {
        BM_LSL   = 4'd0,
        BM_LSR   = 4'd1,
        BM_ASR   = 4'd2,
        BM_ROR   = 4'd3,
        BM_REV   = 4'd4,
        BM_REV16 = 4'd5,
        BM_REVSH = 4'd6,
        BM_SXTB  = 4'd7,
        BM_SXTH  = 4'd8,
        BM_UXTB  = 4'd9,
        BM_UXTH  = 4'd10
    } bm_op_e;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } sh_kind_e;

endpackage

// File: rtl/bitmove_shift.sv
// Module: barrel shifter and rotator with carry-out.
// Does:   left/right logical, arithmetic right and right rotate by AMT_BITS amount.
// Assumes: DATA_W is a power of two; the amount is already selected by the caller.
module bitmove_shift
    import bitmove_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int AMT_BITS = 8
) (
    input  sh_kind_e            kind_i,
    input  logic [AMT_BITS-1:0] amt_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic                cin_i,
    output logic [DATA_W-1:0]   res_o,
    output logic                cout_o
);

    localparam int W2    = 2 * DATA_W;
    localparam int ROT_W = $clog2(DATA_W);

    logic [W2-1:0]        lsl_t;
    logic [W2-1:0]        lsr_t;
    logic signed [W2-1:0] asr_t;
    logic [W2-1:0]        ror_t;
    logic [ROT_W-1:0]     rot_m;
    logic [ROT_W-1:0]     rot_prev;
    logic                 ror_c;

    // Purpose: build every shift on a double-width vector so the last bit out lands at a fixed position.
    always_comb begin
        lsl_t    = {{DATA_W{1'b0}}, data_i} << amt_i;
        lsr_t    = {data_i, {DATA_W{1'b0}}} >> amt_i;
        asr_t    = $signed({data_i, {DATA_W{1'b0}}}) >>> amt_i;
        rot_m    = amt_i[ROT_W-1:0];
        ror_t    = {data_i, data_i} >> rot_m;
        rot_prev = rot_m - 1'b1;
        ror_c    = data_i[rot_prev];
    end

    // Purpose: pick the requested kind and hold data and carry for a zero amount.
    always_comb begin
        res_o  = data_i;
        cout_o = cin_i;
        if (amt_i != '0) begin
            case (kind_i)
                SK_LSL: begin
                    res_o  = lsl_t[DATA_W-1:0];
                    cout_o = lsl_t[DATA_W];
                end
                SK_LSR: begin
                    res_o  = lsr_t[W2-1:DATA_W];
                    cout_o = lsr_t[DATA_W-1];
                end
                SK_ASR: begin
                    res_o  = asr_t[W2-1:DATA_W];
                    cout_o = asr_t[DATA_W-1];
                end
                default: begin
                    res_o  = ror_t[DATA_W-1:0];
                    cout_o = ror_c;
                end
            endcase
        end
    end

    // Purpose: guard rotate carry and zero-amount hold.
    always_comb begin
        if (kind_i == SK_ROR && amt_i != '0) begin
            a_r7_ror_carry_top: assert (cout_o == res_o[DATA_W-1]);
        end
        if (amt_i == '0) begin
            a_r6_zero_amt_hold: assert (cout_o == cin_i && res_o == data_i);
        end
    end

endmodule

// File: rtl/bitmove_perm.sv
// Module: byte reorder and width extension.
// Does:   whole-word byte reversal, per-halfword byte swap, signed halfword swap,
//         and sign/zero extension of a byte or halfword.
// Assumes: DATA_W is a multiple of 16; non-permute opcodes pass data through.
module bitmove_perm
    import bitmove_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] res_o
);

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int NHALF  = DATA_W / HALF_W;

    logic [DATA_W-1:0] rev_w;
    logic [DATA_W-1:0] rev_h;

    // Purpose: mirror byte lanes across the whole word.
    for (genvar b = 0; b < NBYTES; b++) begin : g_rev_w
        assign rev_w[b*BYTE_W +: BYTE_W] = data_i[(NBYTES-1-b)*BYTE_W +: BYTE_W];
    end

    // Purpose: swap the two byte lanes of every halfword.
    for (genvar h = 0; h < NHALF; h++) begin : g_rev_h
        assign rev_h[h*HALF_W +: BYTE_W]          = data_i[h*HALF_W + BYTE_W +: BYTE_W];
        assign rev_h[h*HALF_W + BYTE_W +: BYTE_W] = data_i[h*HALF_W +: BYTE_W];
    end

    // Purpose: select the permutation or extension named by the opcode.
    always_comb begin
        case (op_i)
            BM_REV:   res_o = rev_w;
            BM_REV16: res_o = rev_h;
            BM_REVSH: res_o = {{(DATA_W-HALF_W){data_i[BYTE_W-1]}},
                               data_i[BYTE_W-1:0], data_i[HALF_W-1:BYTE_W]};
            BM_SXTB:  res_o = {{(DATA_W-BYTE_W){data_i[BYTE_W-1]}}, data_i[BYTE_W-1:0]};
            BM_SXTH:  res_o = {{(DATA_W-HALF_W){data_i[HALF_W-1]}}, data_i[HALF_W-1:0]};
            BM_UXTB:  res_o = {{(DATA_W-BYTE_W){1'b0}}, data_i[BYTE_W-1:0]};
            BM_UXTH:  res_o = {{(DATA_W-HALF_W){1'b0}}, data_i[HALF_W-1:0]};
            default:  res_o = data_i;
        endcase
    end

    // Purpose: guard lane mapping at the word ends.
    always_comb begin
        if (op_i == BM_REV) begin
            a_r8_rev_ends: assert (res_o[BYTE_W-1:0] == data_i[DATA_W-1 -: BYTE_W]
                                   && res_o[DATA_W-1 -: BYTE_W] == data_i[BYTE_W-1:0]);
        end
        if (op_i == BM_REVSH) begin
            a_r10_revsh_sign: assert (res_o[DATA_W-1] == data_i[BYTE_W-1]);
        end
    end

endmodule

// File: rtl/bitmove_flags.sv
// Module: result flag generation.
// Does:   negative from the top bit, zero when no result bit is set.
// Assumes: carry is produced elsewhere.
module bitmove_flags #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res_i,
    output logic              neg_o,
    output logic              zero_o
);

    // Purpose: derive sign and all-zero flags.
    always_comb begin
        neg_o  = res_i[DATA_W-1];
        zero_o = (res_i == '0);
    end

endmodule

// File: rtl/bitmove_unit.sv
// Module: top of the shift, rotate and byte-reorder unit.
// Does:   selects the shift amount source, routes the opcode to the shifter or
//         the permuter, and merges result and flags.
// Assumes: purely combinational; reg_amt_i already holds the register's low byte.
module bitmove_unit
    import bitmove_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int AMT_BITS = 8
) (
    input  logic [3:0]                op_i,
    input  logic                      amt_sel_i,
    input  logic [$clog2(DATA_W)-1:0] imm_amt_i,
    input  logic [AMT_BITS-1:0]       reg_amt_i,
    input  logic [DATA_W-1:0]         a_i,
    input  logic                      carry_i,
    output logic [DATA_W-1:0]         res_o,
    output logic                      neg_o,
    output logic                      zero_o,
    output logic                      carry_o
);

    logic [AMT_BITS-1:0] amt;
    logic                is_shift;
    logic [DATA_W-1:0]   sh_res;
    logic                sh_c;
    logic [DATA_W-1:0]   pm_res;
    sh_kind_e            kind;

    // Purpose: choose the amount source; rotate always uses the register byte.
    always_comb begin
        is_shift = (op_i <= BM_ROR);
        kind     = sh_kind_e'(op_i[1:0]);
        if (op_i == BM_ROR || amt_sel_i) begin
            amt = reg_amt_i;
        end else begin
            amt = AMT_BITS'(imm_amt_i);
        end
    end

    bitmove_shift #(
        .DATA_W  (DATA_W),
        .AMT_BITS(AMT_BITS)
    ) u_shift (
        .kind_i (kind),
        .amt_i  (amt),
        .data_i (a_i),
        .cin_i  (carry_i),
        .res_o  (sh_res),
        .cout_o (sh_c)
    );

    bitmove_perm #(
        .DATA_W(DATA_W)
    ) u_perm (
        .op_i  (op_i),
        .data_i(a_i),
        .res_o (pm_res)
    );

    // Purpose: merge the two datapaths; non-shift opcodes keep the incoming carry.
    always_comb begin
        res_o   = is_shift ? sh_res : pm_res;
        carry_o = is_shift ? sh_c : carry_i;
    end

    bitmove_flags #(
        .DATA_W(DATA_W)
    ) u_flags (
        .res_i (res_o),
        .neg_o (neg_o),
        .zero_o(zero_o)
    );

    // Purpose: guard wide shift saturation and carry pass-through at the ports.
    always_comb begin
        if (op_i == BM_LSL && amt > AMT_BITS'(DATA_W)) begin
            a_r2_lsl_wide_clear: assert (res_o == '0 && carry_o == 1'b0);
        end
        if (op_i == BM_LSR && amt > AMT_BITS'(DATA_W)) begin
            a_r3_lsr_wide_clear: assert (res_o == '0 && carry_o == 1'b0);
        end
        if (op_i > BM_ROR) begin
            a_r12_carry_pass: assert (carry_o == carry_i);
        end
    end

endmodule

// File: tb/bitmove_unit_tb.sv
module bitmove_unit_tb;

    typedef struct {
        logic [31:0] res;
        logic        n;
        logic        z;
        logic        c;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic [3:0]  op_i = '0;
    logic        amt_sel_i = 1'b0;
    logic [4:0]  imm_amt_i = '0;
    logic [7:0]  reg_amt_i = '0;
    logic [31:0] a_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] res_o;
    logic        neg_o, zero_o, carry_o;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    bitmove_unit u_dut (
        .op_i     (op_i),
        .amt_sel_i(amt_sel_i),
        .imm_amt_i(imm_amt_i),
        .reg_amt_i(reg_amt_i),
        .a_i      (a_i),
        .carry_i  (carry_i),
        .res_o    (res_o),
        .neg_o    (neg_o),
        .zero_o   (zero_o),
        .carry_o  (carry_o)
    );

    // Reference model, written bit by bit from the requirements; returns {carry, result}.
    function automatic logic [32:0] model(input logic [3:0] op, input logic sel,
                                          input logic [4:0] imm, input logic [7:0] ramt,
                                          input logic [31:0] a, input logic cin);
        logic [31:0] v = a;
        logic        c = cin;
        int          n;
        n = (op == 4'd3 || sel) ? int'(ramt) : int'(imm);
        case (op)
            4'd0: for (int i = 0; i < n; i++) begin c = v[31]; v = {v[30:0], 1'b0}; end
            4'd1: for (int i = 0; i < n; i++) begin c = v[0];  v = {1'b0, v[31:1]}; end
            4'd2: for (int i = 0; i < n; i++) begin c = v[0];  v = {v[31], v[31:1]}; end
            4'd3: if (n != 0) begin
                      for (int i = 0; i < n % 32; i++) v = {v[0], v[31:1]};
                      c = v[31];
                  end
            4'd4:  v = {a[7:0], a[15:8], a[23:16], a[31:24]};
            4'd5:  v = {a[23:16], a[31:24], a[7:0], a[15:8]};
            4'd6:  v = {{16{a[7]}}, a[7:0], a[15:8]};
            4'd7:  v = {{24{a[7]}}, a[7:0]};
            4'd8:  v = {{16{a[15]}}, a[15:0]};
            4'd9:  v = {24'd0, a[7:0]};
            4'd10: v = {16'd0, a[15:0]};
            default: v = a;
        endcase
        return {c, v};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R7";
            4'd4: return "R8";
            4'd5: return "R9";
            4'd6: return "R10";
            4'd7, 4'd8, 4'd9, 4'd10: return "R11";
            default: return "R1";
        endcase
    endfunction

    // Driver: apply one operation and push its expected outcome.
    task automatic send(input logic [3:0] op, input logic sel, input logic [4:0] imm,
                        input logic [7:0] ramt, input logic [31:0] a, input logic cin,
                        input string tag);
        exp_t        e;
        logic [32:0] m;
        @(posedge clk);
        #1;
        op_i = op; amt_sel_i = sel; imm_amt_i = imm; reg_amt_i = ramt;
        a_i = a; carry_i = cin;
        m     = model(op, sel, imm, ramt, a, cin);
        e.res = m[31:0];
        e.c   = m[32];
        e.n   = m[31];
        e.z   = (m[31:0] == 32'd0);
        e.tag = (tag == "") ? tag_of(op) : tag;
        sb.push_back(e);
    endtask

    // Monitor: compare settled outputs mid-cycle against the scoreboard head.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (res_o !== e.res || neg_o !== e.n || zero_o !== e.z || carry_o !== e.c) begin
                bad++;
                $display("FAIL %s: res=%h n=%b z=%b c=%b expected res=%h n=%b z=%b c=%b",
                         e.tag, res_o, neg_o, zero_o, carry_o, e.res, e.n, e.z, e.c);
            end
        end
    end

    initial begin
        // Idle, all-zero inputs: zero flag set (R12)
        send(4'd0, 1'b0, 5'd0, 8'd0, 32'h0, 1'b0, "R12");
        // R2 left shift corners
        send(4'd0, 1'b0, 5'd4,  8'd0,  32'h8000_000F, 1'b0, "R2");
        send(4'd0, 1'b1, 5'd0,  8'd32, 32'h0000_0001, 1'b0, "R2");
        send(4'd0, 1'b1, 5'd0,  8'd33, 32'hFFFF_FFFF, 1'b1, "R2");
        send(4'd0, 1'b0, 5'd31, 8'd0,  32'h0000_0003, 1'b0, "R2");
        // R3 logical right corners
        send(4'd1, 1'b0, 5'd1,  8'd0,  32'h0000_0003, 1'b0, "R3");
        send(4'd1, 1'b1, 5'd0,  8'd32, 32'h8000_0000, 1'b0, "R3");
        send(4'd1, 1'b1, 5'd0,  8'd200, 32'hFFFF_FFFF, 1'b1, "R3");
        // R4 arithmetic right corners
        send(4'd2, 1'b1, 5'd0,  8'd40, 32'h8000_0001, 1'b0, "R4");
        send(4'd2, 1'b1, 5'd0,  8'd255, 32'h7FFF_FFFF, 1'b1, "R4");
        send(4'd2, 1'b0, 5'd4,  8'd0,  32'hF000_0018, 1'b0, "R4");
        // R5 amount source selection, unused source has no effect
        send(4'd0, 1'b1, 5'd3,  8'd4,  32'h0000_0011, 1'b0, "R5");
        send(4'd0, 1'b0, 5'd3,  8'd31, 32'h0000_0011, 1'b0, "R5");
        send(4'd1, 1'b0, 5'd8,  8'd255, 32'hABCD_1234, 1'b0, "R5");
        // R6 zero amount keeps data and carry
        send(4'd0, 1'b0, 5'd0,  8'd9,  32'h8765_4321, 1'b1, "R6");
        send(4'd2, 1'b1, 5'd9,  8'd0,  32'h8765_4321, 1'b0, "R6");
        send(4'd3, 1'b1, 5'd0,  8'd0,  32'h8765_4321, 1'b1, "R6");
        // R7 rotate: register amount only, modulo 32
        send(4'd3, 1'b1, 5'd0,  8'd8,  32'h1234_5678, 1'b1, "R7");
        send(4'd3, 1'b0, 5'd4,  8'd8,  32'h1234_5678, 1'b1, "R7");
        send(4'd3, 1'b1, 5'd0,  8'd32, 32'h8000_0001, 1'b0, "R7");
        send(4'd3, 1'b1, 5'd0,  8'd36, 32'h0000_000F, 1'b0, "R7");
        // R8..R11 byte reorder and extension
        send(4'd4,  1'b0, 5'd0, 8'd0, 32'h1122_3344, 1'b1, "R8");
        send(4'd5,  1'b0, 5'd0, 8'd0, 32'h1122_3344, 1'b0, "R9");
        send(4'd6,  1'b0, 5'd0, 8'd0, 32'h0000_1280, 1'b0, "R10");
        send(4'd6,  1'b0, 5'd0, 8'd0, 32'hFFFF_8012, 1'b0, "R10");
        send(4'd7,  1'b0, 5'd0, 8'd0, 32'h1234_5680, 1'b0, "R11");
        send(4'd8,  1'b0, 5'd0, 8'd0, 32'h1234_8001, 1'b0, "R11");
        send(4'd9,  1'b0, 5'd0, 8'd0, 32'hFFFF_FF80, 1'b0, "R11");
        send(4'd10, 1'b0, 5'd0, 8'd0, 32'hFFFF_8001, 1'b0, "R11");
        // R1 undefined codes, R12 flags on a zero result from an extension
        send(4'd11, 1'b1, 5'd7, 8'd7, 32'hCAFE_F00D, 1'b1, "R1");
        send(4'd15, 1'b0, 5'd7, 8'd7, 32'h0000_0000, 1'b0, "R1");
        send(4'd9,  1'b0, 5'd0, 8'd0, 32'hFFFF_FF00, 1'b1, "R12");
        // Random sweep across all opcodes
        for (int i = 0; i < 400; i++) begin
            send(4'($urandom_range(0, 15)), 1'($urandom), 5'($urandom),
                 8'($urandom_range(0, 70)), $urandom, 1'($urandom), "");
        end
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule